// File: doc/BRIEF.md
# Carry Flag Selection Unit

This block sits next to an 8-bit ALU and the flag storage of a small processor core. It works out three one-bit values from control lines sent by the instruction decoder. The first is the value offered to the carry flag. The second is the carry fed into the ALU's least significant bit. The third is the serial bit shifted into the ALU's most significant bit during a right shift.

The carry result is taken from one of four sources and then passes through an inversion stage. That stage turns a carry into a borrow, complements the flag, and, with no source selected, forces the flag to 1 or 0. The ALU carry-in can be a constant, the current carry flag (optionally inverted), or a private held carry. The held carry is captured from the ALU's bit-7 carry during the low byte of a two-step 16-bit add-constant. It is then fed into the high byte while the visible carry flag stays untouched.

A single shared select line does two jobs. It routes the held carry to the ALU carry-in, and it routes accumulator-temp bit 0 to the shift-right input for circular rotates. The instructions that use these two paths never need them at the same time. The source select is either one-hot or binary-coded, depending on a parameter.

Top module: `carry_sel_unit`

## Requirements
- R1: When the ALU-carry source is selected (one-hot bit 0, code 1) and no inversion is requested, `cy_res` equals `alu_c7`.
- R2: When the decimal-adjust source is selected (one-hot bit 1, code 2), the pre-inversion value is `daa_hi_ge10`.
- R3: When the flag source is selected (one-hot bit 2, code 3), the pre-inversion value is `cy_flag`; together with inversion this complements the flag.
- R4: When the accumulator-temp source is selected (one-hot bit 3, code 4), the pre-inversion value is `act_b0`.
- R5: `cy_res` is the pre-inversion value XOR `xor_res`. With no source selected the pre-inversion value is 0, so `cy_res` equals `xor_res`, which gives set-carry (1) and clear-carry (0).
- R6: In one-hot form, several set select bits give the OR of their sources. In coded form, codes 0, 5, 6 and 7 select nothing.
- R7: With `hold_rot_sel` and `cin_flag_sel` both low, `cy_in` equals the constant `xor_cin`.
- R8: With `cin_flag_sel` high and `hold_rot_sel` low, `cy_in` equals `cy_flag` XOR `xor_cin`.
- R9: With `hold_rot_sel` high, `cy_in` equals the held carry regardless of `cin_flag_sel`, `xor_cin` and `cy_flag`.
- R10: The held carry loads `alu_c7` on a rising clock edge with `hold_cap` high and keeps its value otherwise. It resets to 0 asynchronously while `rst_n` is low.
- R11: `shr_in` equals `act_b0` when `hold_rot_sel` is high and `cy_flag` otherwise.
- R12: The held carry never reaches `cy_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held carry |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_sel | input | SEL_W | Carry result source select (one-hot 4 bits, or coded 3 bits) |
| xor_res | input | 1 | Invert the selected carry result |
| alu_c7 | input | 1 | ALU carry out of bit 7 |
| daa_hi_ge10 | input | 1 | Decimal-adjust high digit is 10 or more |
| act_b0 | input | 1 | Accumulator-temp bit 0 |
| cy_flag | input | 1 | Current architectural carry flag |
| cin_flag_sel | input | 1 | Use the carry flag as ALU carry-in |
| xor_cin | input | 1 | Constant carry-in value, or inversion of the flag carry-in |
| hold_rot_sel | input | 1 | Shared line: held carry to carry-in, act bit 0 to shift input |
| hold_cap | input | 1 | Capture `alu_c7` into the held carry |
| cy_res | output | 1 | Value offered to the carry flag |
| cy_in | output | 1 | ALU carry-in |
| shr_in | output | 1 | Serial input to the ALU top bit on right shifts |

## Verification
The bench builds two copies side by side: one with `ONE_HOT_SEL = 1` (a 4-bit select) and one with `ONE_HOT_SEL = 0` (a 3-bit code). Both are driven from the same stimulus. The one-hot copy makes overlapping selects reachable, where the sources are ORed. The coded copy reaches the unused codes 5 to 7. The shared held carry is exercised in both through capture, hold, recapture of 0, and a reset in mid-run.

// File: rtl/carry_sel_pkg.sv
package carry_sel_pkg;

  // number of carry result sources and their positions in the enable vector
  localparam int NUM_SRC  = 4;
  localparam int SRC_ALU  = 0;
  localparam int SRC_DAA  = 1;
  localparam int SRC_FLAG = 2;
  localparam int SRC_ACT  = 3;

  // OR of every enabled source; zero when nothing is enabled
  function automatic logic merge_sources(input logic [NUM_SRC-1:0] en,
                                         input logic [NUM_SRC-1:0] val);
    return |(en & val);
  endfunction

  // ALU carry-in steering: held carry wins, then flag (optionally inverted), then constant
  function automatic logic steer_cin(input logic use_held,
                                     input logic use_flag,
                                     input logic inv,
                                     input logic flag,
                                     input logic held);
    logic r;
    if (use_held)      r = held;
    else if (use_flag) r = flag ^ inv;
    else               r = inv;
    return r;
  endfunction

endpackage

// File: rtl/cy_src_decode.sv
module cy_src_decode
  import carry_sel_pkg::*;
#(
  parameter bit ONE_HOT_SEL = 1'b1,
  parameter int SEL_W       = NUM_SRC
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_SRC-1:0] en
);

  generate
    if (ONE_HOT_SEL) begin : g_onehot
      assign en = sel[NUM_SRC-1:0];
    end else begin : g_coded
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
        assign en[i] = (sel == SEL_W'(i + 1));
      end
    end
  endgenerate

endmodule

// File: rtl/cy_result_mux.sv
module cy_result_mux
  import carry_sel_pkg::*;
(
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] val,
  input  logic               inv,
  output logic               pre,
  output logic               res
);

  always_comb begin
    pre = merge_sources(en, val);
    res = pre ^ inv;
  end

endmodule

// File: rtl/cy_edge_steer.sv
module cy_edge_steer
  import carry_sel_pkg::*;
(
  input  logic shared_sel,
  input  logic use_flag,
  input  logic inv,
  input  logic flag,
  input  logic held,
  input  logic act_lsb,
  output logic cin,
  output logic shr
);

  always_comb begin
    cin = steer_cin(shared_sel, use_flag, inv, flag, held);
    shr = shared_sel ? act_lsb : flag;
  end

endmodule

// File: rtl/cy_hold_reg.sv
module cy_hold_reg #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RESET_VAL;
    else if (cap) q <= d;
  end

endmodule

// File: rtl/carry_sel_unit.sv
module carry_sel_unit
  import carry_sel_pkg::*;
#(
  parameter bit ONE_HOT_SEL = 1'b1,
  localparam int SEL_W = ONE_HOT_SEL ? NUM_SRC : $clog2(NUM_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             xor_res,
  input  logic             alu_c7,
  input  logic             daa_hi_ge10,
  input  logic             act_b0,
  input  logic             cy_flag,
  input  logic             cin_flag_sel,
  input  logic             xor_cin,
  input  logic             hold_rot_sel,
  input  logic             hold_cap,
  output logic             cy_res,
  output logic             cy_in,
  output logic             shr_in
);

  // named internal events, visible to the bound checker
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] src_val;
  logic               res_pre;
  logic               held_cy;

  always_comb begin
    src_val           = '0;
    src_val[SRC_ALU]  = alu_c7;
    src_val[SRC_DAA]  = daa_hi_ge10;
    src_val[SRC_FLAG] = cy_flag;
    src_val[SRC_ACT]  = act_b0;
  end

  cy_src_decode #(
    .ONE_HOT_SEL (ONE_HOT_SEL),
    .SEL_W       (SEL_W)
  ) u_dec (
    .sel (res_sel),
    .en  (src_en)
  );

  cy_result_mux u_res (
    .en  (src_en),
    .val (src_val),
    .inv (xor_res),
    .pre (res_pre),
    .res (cy_res)
  );

  cy_hold_reg #(
    .RESET_VAL (1'b0)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (hold_cap),
    .d     (alu_c7),
    .q     (held_cy)
  );

  cy_edge_steer u_edge (
    .shared_sel (hold_rot_sel),
    .use_flag   (cin_flag_sel),
    .inv        (xor_cin),
    .flag       (cy_flag),
    .held       (held_cy),
    .act_lsb    (act_b0),
    .cin        (cy_in),
    .shr        (shr_in)
  );

endmodule

// File: rtl/carry_sel_chk.sv
module carry_sel_chk
  import carry_sel_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_en,
  input logic               xor_res,
  input logic               alu_c7,
  input logic               cy_flag,
  input logic               cin_flag_sel,
  input logic               xor_cin,
  input logic               hold_rot_sel,
  input logic               hold_cap,
  input logic               held_cy,
  input logic               cy_res,
  input logic               cy_in,
  input logic               shr_in
);

  // R10
  held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cap |=> held_cy == $past(alu_c7));

  // R10
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_cap |=> $stable(held_cy));

  // R9
  cin_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rot_sel |-> cy_in == held_cy);

  // R7
  cin_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_rot_sel && !cin_flag_sel) |-> cy_in == xor_cin);

  // R11
  shr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_rot_sel |-> shr_in == cy_flag);

  // R5
  res_nosrc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |-> cy_res == xor_res);

  // R1
  res_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == NUM_SRC'(1) && !xor_res) |-> cy_res == alu_c7);

endmodule

bind carry_sel_unit carry_sel_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_en       (src_en),
  .xor_res      (xor_res),
  .alu_c7       (alu_c7),
  .cy_flag      (cy_flag),
  .cin_flag_sel (cin_flag_sel),
  .xor_cin      (xor_cin),
  .hold_rot_sel (hold_rot_sel),
  .hold_cap     (hold_cap),
  .held_cy      (held_cy),
  .cy_res       (cy_res),
  .cy_in        (cy_in),
  .shr_in       (shr_in)
);

// File: tb/test_carry_sel_unit.sv
module test_carry_sel_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel_oh = '0;
  logic [2:0] sel_cd = '0;
  logic       xor_res = 0, alu_c7 = 0, daa_hi_ge10 = 0, act_b0 = 0, cy_flag = 0;
  logic       cin_flag_sel = 0, xor_cin = 0, hold_rot_sel = 0, hold_cap = 0;
  logic       res_a, cin_a, shr_a, res_b, cin_b, shr_b;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  carry_sel_unit #(.ONE_HOT_SEL(1'b1)) i_carry_sel_unit (
    .clk(clk), .rst_n(rst_n), .res_sel(sel_oh), .xor_res(xor_res),
    .alu_c7(alu_c7), .daa_hi_ge10(daa_hi_ge10), .act_b0(act_b0),
    .cy_flag(cy_flag), .cin_flag_sel(cin_flag_sel), .xor_cin(xor_cin),
    .hold_rot_sel(hold_rot_sel), .hold_cap(hold_cap),
    .cy_res(res_a), .cy_in(cin_a), .shr_in(shr_a));

  carry_sel_unit #(.ONE_HOT_SEL(1'b0)) i_carry_sel_unit_cd (
    .clk(clk), .rst_n(rst_n), .res_sel(sel_cd), .xor_res(xor_res),
    .alu_c7(alu_c7), .daa_hi_ge10(daa_hi_ge10), .act_b0(act_b0),
    .cy_flag(cy_flag), .cin_flag_sel(cin_flag_sel), .xor_cin(xor_cin),
    .hold_rot_sel(hold_rot_sel), .hold_cap(hold_cap),
    .cy_res(res_b), .cy_in(cin_b), .shr_in(shr_b));

  // {sel[3:0] (alu,daa,flag,act from bit0), src[3:0] same order,
  //  xor_res, cin_flag_sel, xor_cin, hold_rot_sel, exp res, exp cin, exp shr, 0}
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    16'b0001_0001_0000_1000,
    16'b0001_1110_0000_0010,
    16'b0001_0001_1000_0000,
    16'b0010_0010_0100_1000,
    16'b0010_1101_0110_0010,
    16'b0100_0100_1100_0110,
    16'b0100_0000_1010_1100,
    16'b1000_1000_0001_1010,
    16'b1000_0111_0111_0000,
    16'b0000_1111_1000_1010,
    16'b0000_1111_0000_0010,
    16'b0011_0010_0000_1000,
    16'b1100_0000_1000_1000,
    16'b0101_0000_0000_0000
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] to_code(input logic [3:0] oh);
    logic [2:0] c = 3'd0;
    for (int i = 0; i < 4; i++) if (oh[i]) c = 3'(i + 1);
    return c;
  endfunction

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // reset state: held carry is 0
    hold_rot_sel = 1'b1;
    #3;
    chk("R10 reset held carry one-hot", cin_a, 1'b0);
    chk("R10 reset held carry coded", cin_b, 1'b0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hold_rot_sel = 1'b0;

    // vector table (R1 R2 R3 R4 R5 R6 R7 R8 R9 R11)
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      sel_oh       = VEC[k][15:12];
      alu_c7       = VEC[k][8];
      daa_hi_ge10  = VEC[k][9];
      cy_flag      = VEC[k][10];
      act_b0       = VEC[k][11];
      xor_res      = VEC[k][7];
      cin_flag_sel = VEC[k][6];
      xor_cin      = VEC[k][5];
      hold_rot_sel = VEC[k][4];
      sel_cd       = to_code(VEC[k][15:12]);
      #1;
      chk($sformatf("table %0d result R1 R2 R3 R4 R5 R6", k), res_a, VEC[k][3]);
      chk($sformatf("table %0d carry-in R7 R8 R9", k), cin_a, VEC[k][2]);
      chk($sformatf("table %0d shift-in R11", k), shr_a, VEC[k][1]);
      if ($countones(VEC[k][15:12]) <= 1)
        chk($sformatf("table %0d coded result R1 R2 R3 R4 R5", k), res_b, VEC[k][3]);
    end

    // R10: capture a 1
    @(negedge clk);
    sel_oh = '0; sel_cd = '0; xor_res = 0; cin_flag_sel = 0; xor_cin = 0;
    hold_rot_sel = 0; alu_c7 = 1; hold_cap = 1; cy_flag = 0; act_b0 = 0;
    @(negedge clk);
    hold_cap = 0; alu_c7 = 0;
    hold_rot_sel = 1; cin_flag_sel = 1; xor_cin = 1;
    #1;
    chk("R10 capture 1", cin_a, 1'b1);
    chk("R9 held overrides flag and inversion", cin_b, 1'b1);
    chk("R12 held carry absent from result", res_a, 1'b0);
    sel_oh = 4'b0001; sel_cd = 3'd1;
    #1;
    chk("R12 held carry absent with alu source", res_a, 1'b0);
    chk("R11 shift-in from act bit 0", shr_a, 1'b0);
    act_b0 = 1;
    #1;
    chk("R11 shift-in follows act bit 0", shr_a, 1'b1);
    @(negedge clk);
    #1;
    chk("R10 hold without capture", cin_a, 1'b1);

    // R10: capture a 0
    hold_cap = 1; alu_c7 = 0;
    @(negedge clk);
    hold_cap = 0;
    #1;
    chk("R10 capture 0", cin_a, 1'b0);
    chk("R9 held 0 with inversion requested", cin_b, 1'b0);

    // R8: flag path with inversion
    hold_rot_sel = 0; cin_flag_sel = 1; xor_cin = 1; cy_flag = 0;
    #1;
    chk("R8 inverted flag carry-in", cin_a, 1'b1);

    // R6: unused codes select nothing in the coded variant
    for (int c = 5; c < 8; c++) begin
      sel_cd = 3'(c); alu_c7 = 1; daa_hi_ge10 = 1; cy_flag = 1; act_b0 = 1;
      xor_res = 0;
      #1;
      chk($sformatf("R6 coded %0d no source", c), res_b, 1'b0);
      xor_res = 1;
      #1;
      chk($sformatf("R6 coded %0d inverted", c), res_b, 1'b1);
    end

    // R10: reset in mid-run clears the held carry
    @(negedge clk);
    alu_c7 = 1; hold_cap = 1; hold_rot_sel = 1;
    @(negedge clk);
    hold_cap = 0;
    #1;
    chk("R10 recapture before reset", cin_a, 1'b1);
    rst_n = 0;
    #1;
    chk("R10 asynchronous reset", cin_a, 1'b0);
    chk("R10 asynchronous reset coded", cin_b, 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule